// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block is the front end for 28 external interrupt lines. Each line passes through a two-flop synchroniser and then a trigger detector. The detector works in one of five modes: low level, high level, falling edge, rising edge or both edges. Two adjacent lines share one 3-bit mode field. A detected trigger sets the line's pending bit. Software clears a pending bit by writing a one to it.

A shared mask register gates the pending bits. The unmasked pending bits are ORed into four group request outputs, which feed a downstream vectored interrupt controller. The four groups cover lines 0–3, 4–11, 12–19 and 20–27. Software reaches the mode, mask and pending state through a small synchronous register port. The port has an address, a write strobe, write data and registered read data.

Top module: `eint_group_ctrl`

## Requirements
- R1: After reset every pending bit is 0, every mask bit reads 1 (MASK reads 0x0FFFFFFF), every mode field is 000, and all four group outputs are 0. The synchroniser and edge history flops reset to 1, so lines that are held high raise nothing after reset.
- R2: Register addresses are 0 = CFG_LO, 1 = CFG_HI, 2 = MASK and 3 = PEND. Line n uses mode field n/2. In CFG_LO, lines 0–15 use bits [(n/2)*4 +: 3]. In CFG_HI, lines 16–27 use bits [((n-16)/2)*4 +: 3]. Bit 3 of each nibble and bits 31:24 of CFG_HI read as 0.
- R3: The mode codes are 000 = low level, 001 = high level, 01x = falling edge, 10x = rising edge and 11x = both edges.
- R4: In a level mode the pending bit sets on every cycle the synchronised level is active. A write-one-to-clear in that cycle does not clear the bit.
- R5: In an edge mode the pending bit sets only on a matching edge of the synchronised input. A level that stays constant does not set it again after it is cleared. A mismatched edge has no effect.
- R6: A MASK bit of 1 blocks its line from the group outputs and a bit of 0 passes it. MASK reads back the value written in bits 27:0, so read-modify-write works. Masking never changes PEND.
- R7: Writing 1 to a PEND bit clears that bit and writing 0 leaves it unchanged. PEND reads the raw pending state whatever the mask holds.
- R8: irq_grp[0] is the OR of pending AND NOT mask over lines 0–3. irq_grp[1] covers lines 4–11, irq_grp[2] covers lines 12–19 and irq_grp[3] covers lines 20–27.
- R9: Read data is registered: bus_rdata shows the register selected by bus_addr one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 28 | Asynchronous external interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq_grp | output | 4 | Grouped interrupt requests |

## Verification
The hardest case to reach is a write-one-to-clear that lands in the same cycle as an active level trigger. Here the trigger must win, and the edge-mode bit must stay clear afterwards. To reach it, the stimulus holds a level-mode line active, issues the clear, and reads PEND back. It then does the same for an edge-mode line held at its post-edge level. The shared mode fields are probed by driving the partner line of a configured line, so both lines of one field are shown to follow the same code.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int NLINES  = 28;
  localparam int DW      = 32;
  localparam int FW      = 3;
  localparam int STRIDE  = 4;
  localparam int FPR     = DW / STRIDE;
  localparam int NFIELDS = (NLINES + 1) / 2;
  localparam int NGRP    = 4;
  localparam int AW      = 2;
  localparam int G1_BASE = 4;
  localparam int G2_BASE = 12;
  localparam int G3_BASE = 20;

  typedef enum logic [AW-1:0] {
    A_CFG_LO = 2'd0,
    A_CFG_HI = 2'd1,
    A_MASK   = 2'd2,
    A_PEND   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic edge_fall;
    logic edge_rise;
  } trig_sel_t;

  // Mode code to trigger selection.
  function automatic trig_sel_t decode_mode(input logic [FW-1:0] code);
    trig_sel_t s;
    s = '0;
    unique case (code[2:1])
      2'b00: begin
        s.lvl_hi = code[0];
        s.lvl_lo = ~code[0];
      end
      2'b01: s.edge_fall = 1'b1;
      2'b10: s.edge_rise = 1'b1;
      default: begin
        s.edge_fall = 1'b1;
        s.edge_rise = 1'b1;
      end
    endcase
    return s;
  endfunction

  // Group index of a line (unequal ranges).
  function automatic int grp_of(input int line);
    if (line < G1_BASE)      return 0;
    else if (line < G2_BASE) return 1;
    else if (line < G3_BASE) return 2;
    else                     return 3;
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINES-1:0]     lvl,
  input  logic [NFIELDS*FW-1:0] cfg_flat,
  output logic [NLINES-1:0]     trig
);
  logic [NLINES-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= '1;
    else        prv_q <= lvl;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    trig_sel_t sel;
    logic      rise_ev;
    logic      fall_ev;
    assign sel     = decode_mode(cfg_flat[(i/2)*FW +: FW]);
    assign rise_ev = ~prv_q[i] & lvl[i];
    assign fall_ev = prv_q[i] & ~lvl[i];
    assign trig[i] = (sel.lvl_lo & ~lvl[i]) | (sel.lvl_hi & lvl[i]) |
                     (sel.edge_fall & fall_ev) | (sel.edge_rise & rise_ev);

    // R5: an edge-mode trigger needs a real change of the synchronised input
    a_r5_edge_real: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && !sel.lvl_lo && !sel.lvl_hi) |-> (lvl[i] != prv_q[i]));
  end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  input  logic [NLINES-1:0]     trig,
  output logic [DW-1:0]         rdata,
  output logic [NLINES-1:0]     mask,
  output logic [NLINES-1:0]     pend,
  output logic [NFIELDS*FW-1:0] cfg_flat
);
  logic [NFIELDS-1:0][FW-1:0] cfg_q;
  logic [NLINES-1:0]          mask_q;
  logic [NLINES-1:0]          pend_q;
  logic [NLINES-1:0]          clr;
  logic [DW-1:0]              lo_word;
  logic [DW-1:0]              hi_word;
  logic [DW-1:0]              rdata_q;
  logic                       unused_wbits;

  assign unused_wbits = ^wdata;
  assign clr = (we && addr == A_PEND) ? wdata[NLINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | trig;
      if (we && addr == A_MASK) mask_q <= wdata[NLINES-1:0];
      if (we && addr == A_CFG_LO)
        for (int f = 0; f < FPR; f++) cfg_q[f] <= wdata[f*STRIDE +: FW];
      if (we && addr == A_CFG_HI)
        for (int f = FPR; f < NFIELDS; f++) cfg_q[f] <= wdata[(f-FPR)*STRIDE +: FW];
    end
  end

  always_comb begin
    lo_word = '0;
    hi_word = '0;
    for (int f = 0; f < FPR; f++) lo_word[f*STRIDE +: FW] = cfg_q[f];
    for (int f = FPR; f < NFIELDS; f++) hi_word[(f-FPR)*STRIDE +: FW] = cfg_q[f];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else begin
      unique case (addr)
        A_CFG_LO: rdata_q <= lo_word;
        A_CFG_HI: rdata_q <= hi_word;
        A_MASK:   rdata_q <= {{(DW-NLINES){1'b0}}, mask_q};
        default:  rdata_q <= {{(DW-NLINES){1'b0}}, pend_q};
      endcase
    end
  end

  assign rdata    = rdata_q;
  assign mask     = mask_q;
  assign pend     = pend_q;
  assign cfg_flat = cfg_q;

  // R7: a cleared bit with no trigger that cycle is gone on the next cycle
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_PEND) |=> ((pend_q & $past(clr & ~trig)) == '0));
  // R7: pending bits fall only where a one was written
  a_r7_no_spurious_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_q) |=> ((($past(pend_q) & ~pend_q) & ~$past(clr)) == '0));
  // R5: a pending bit rises only after a detected trigger
  a_r5_set_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (~|trig) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/eint_group_ctrl.sv
module eint_group_ctrl
  import eint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_in,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NGRP-1:0]   irq_grp
);
  logic [NLINES-1:0]     lvl_sync;
  logic [NLINES-1:0]     trig;
  logic [NLINES-1:0]     mask;
  logic [NLINES-1:0]     pend;
  logic [NLINES-1:0]     active;
  logic [NFIELDS*FW-1:0] cfg_flat;

  eint_sync #(.W(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
  );

  eint_detect u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .cfg_flat(cfg_flat), .trig(trig)
  );

  eint_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .trig(trig), .rdata(bus_rdata), .mask(mask), .pend(pend), .cfg_flat(cfg_flat)
  );

  assign active = pend & ~mask;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NLINES; i++)
        if (grp_of(i) == g) hit = hit | active[i];
    end
    assign irq_grp[g] = hit;
  end

  // R8: a group request needs some unmasked pending line
  a_r8_grp_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_grp) |-> (|(pend & ~mask)));
  // R6: a fully masked block raises no group request
  a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> (irq_grp == '0));
endmodule

// File: tb/tb_eint_group_ctrl.sv
module tb_eint_group_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] pin_in = '1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_grp;

  eint_group_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_grp(irq_grp)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items when they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {28'd0, irq_grp} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  localparam logic [1:0] CFG_LO = 2'd0, CFG_HI = 2'd1, MASK = 2'd2, PEND = 2'd3;

  // Field placement restated from R2
  function automatic logic [31:0] put_mode(input logic [31:0] word, input int line,
                                           input logic [2:0] code);
    int sh;
    sh = ((line % 16) >> 1) << 2;
    return (word & ~(32'h7 << sh)) | ({29'd0, code} << sh);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    q.push_back('{cyc + 1, 1'b0, e, t});
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    q.push_back('{cyc + 1, 1'b1, {28'd0, e}, t});
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] lo, hi, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    rd(PEND, 32'h0, "R1 pend reset");
    rd(MASK, 32'h0FFFFFFF, "R1 mask reset");
    rd(CFG_LO, 32'h0, "R1 cfg_lo reset");
    rd(CFG_HI, 32'h0, "R1 cfg_hi reset");
    chk_irq(4'h0, "R1 irq reset");

    // R2 layout and unused bits; R9 registered read
    wr(CFG_LO, 32'hFFFFFFFF);
    wr(CFG_HI, 32'hFFFFFFFF);
    rd(CFG_LO, 32'h77777777, "R2 cfg_lo fields");
    rd(CFG_HI, 32'h00777777, "R2 cfg_hi fields");
    rd(MASK, 32'h0FFFFFFF, "R9 addr switch");
    lo = 32'h77777777; hi = 32'h00777777;

    // R3 both edges: falling on lines 4,5
    pin_in[5:4] = 2'b00;
    settle();
    rd(PEND, 32'h00000030, "R3 both-edge falling");
    wr(PEND, 32'h00000030);
    rd(PEND, 32'h0, "R7 w1c");

    // R4 level high on line 5 (field shared with 4)
    lo = put_mode(lo, 5, 3'b001);
    wr(CFG_LO, lo);
    rd(CFG_LO, 32'h77777177, "R2 line5 field");
    pin_in[5] = 1'b1;
    settle();
    rd(PEND, 32'h00000020, "R7 raw pend while masked");
    chk_irq(4'h0, "R6 masked line quiet");
    m = 32'h0FFFFFDF;
    wr(MASK, m);
    rd(MASK, m, "R6 mask readback");
    chk_irq(4'b0010, "R8 group 4-11");
    wr(PEND, 32'h0);
    rd(PEND, 32'h00000020, "R7 write zero no effect");
    wr(PEND, 32'h00000020);
    rd(PEND, 32'h00000020, "R4 level reasserts after clear");
    pin_in[5] = 1'b0;
    settle();
    wr(PEND, 32'h00000020);
    rd(PEND, 32'h0, "R4 level gone clear sticks");
    chk_irq(4'h0, "R8 group drops");

    // R5 rising edge on line 17
    hi = put_mode(hi, 17, 3'b100);
    wr(CFG_HI, hi);
    rd(CFG_HI, 32'h00777774, "R2 line17 field");
    pin_in[17] = 1'b0;
    settle();
    rd(PEND, 32'h0, "R5 falling ignored in rising mode");
    pin_in[17] = 1'b1;
    settle();
    rd(PEND, 32'h00020000, "R5 rising sets");
    m[17] = 1'b0;
    wr(MASK, m);
    chk_irq(4'b0100, "R8 group 12-19");
    wr(PEND, 32'h00020000);
    settle();
    rd(PEND, 32'h0, "R5 held level no reset");

    // R3 falling edge on lines 26 and 27 (shared field)
    hi = put_mode(hi, 26, 3'b010);
    wr(CFG_HI, hi);
    m[26] = 1'b0;
    wr(MASK, m);
    pin_in[26] = 1'b0;
    settle();
    rd(PEND, 32'h04000000, "R3 falling edge line26");
    chk_irq(4'b1000, "R8 group 20-27");
    pin_in[27] = 1'b0;
    settle();
    rd(PEND, 32'h0C000000, "R2 partner line27 shares field");

    // R3 low level on line 0
    lo = put_mode(lo, 0, 3'b000);
    wr(CFG_LO, lo);
    settle();
    rd(PEND, 32'h0C000000, "R3 low level idle high");
    pin_in[0] = 1'b0;
    settle();
    rd(PEND, 32'h0C000001, "R3 low level sets");
    m[0] = 1'b0;
    wr(MASK, m);
    chk_irq(4'b1001, "R8 groups 0-3 and 20-27");
    wr(PEND, 32'h0C000000);
    rd(PEND, 32'h00000001, "R7 selective clear");
    chk_irq(4'b0001, "R8 group 0-3 only");
    wr(PEND, 32'h00000001);
    rd(PEND, 32'h00000001, "R4 low level reasserts");
    pin_in[0] = 1'b1;
    settle();
    wr(PEND, 32'h00000001);
    rd(PEND, 32'h0, "R4 cleared after release");
    chk_irq(4'h0, "R8 all quiet");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
    end
    finish_run();
  end
endmodule